// File: doc/BRIEF.md
# River Crossing Ferry State Machine

This block keeps track of the farmer, fox, goose and cabbage in the classic river puzzle. Each participant has one bank bit. A move request names either the farmer crossing alone or the farmer ferrying one cargo item. The block checks each request, applies it when it is allowed and reports through registered outputs whether the puzzle has been solved.

A request is dropped without any report when the chosen cargo is on the other bank from the farmer, because he cannot load it there. A request that would leave the fox alone with the goose, or the goose alone with the cabbage, is refused. In that case the configuration is held and a single-cycle reject pulse is raised. Search for a solution is left to whatever drives the block. The active-low reset puts everyone back on the near bank.

Top module: `river_ferry_fsm`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bank` is 4'b0000, `move_reject` is 0 and `solved` is 0.
- R2: `bank` bit 0 is the farmer, bit 1 the fox, bit 2 the goose and bit 3 the cabbage. A bit value of 1 means the far bank. A valid move with `move_sel` = 0 toggles only bit 0 on the next clock edge, provided the result is safe.
- R3: A valid move with `move_sel` = 1 (fox), 2 (goose) or 3 (cabbage) toggles bit 0 and bit `move_sel` together on the next edge. This requires the item to share the farmer's bank and the result to be safe.
- R4: A valid cargo move whose item is not on the farmer's bank leaves `bank` unchanged and raises no reject.
- R5: A move that would leave the fox and goose on one bank without the farmer is refused. `bank` is held and `move_reject` is 1 for the following cycle.
- R6: A move that would leave the goose and cabbage on one bank without the farmer is refused in the same way.
- R7: While `move_valid` is 0, `bank` stays unchanged and `move_reject` is 0.
- R8: `solved` is 1 exactly when `bank` is 4'b1111.
- R9: `move_reject` lasts one cycle per refused move. It is 0 in any cycle not directly preceded by a refused move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the start configuration |
| move_valid | input | 1 | Move request strobe, sampled each rising edge |
| move_sel | input | 2 | 0 farmer alone, 1 fox, 2 goose, 3 cabbage |
| bank | output | 4 | Bank of farmer, fox, goose, cabbage (bits 0..3), 1 = far |
| move_reject | output | 1 | One-cycle pulse after a refused unsafe move |
| solved | output | 1 | All four participants are on the far bank |

## Verification
A corrupted bank bit is visible on `bank` in the cycle right after the edge that wrote it. It also changes which later moves are ignored, accepted or refused, so the error keeps showing up in every step that follows. A bad safety decision shows as an unsafe `bank` value, or as a missing or extra `move_reject` pulse, one cycle after the request. The bench therefore compares all three outputs against its own model on every cycle. It does this both along the known seven-move solution and under long random move streams.

// File: rtl/ferry_pkg.sv
package ferry_pkg;
    localparam int unsigned PARTY_N    = 4;
    localparam int unsigned SEL_W      = $clog2(PARTY_N);
    localparam int unsigned FARMER_IDX = 0;
    localparam int unsigned CLASH_N    = 2;
    // predator/prey index pairs that must not be left without the farmer
    localparam int unsigned CLASH_EATER [CLASH_N] = '{1, 2};
    localparam int unsigned CLASH_EATEN [CLASH_N] = '{2, 3};

    typedef logic [PARTY_N-1:0] bank_t;

    typedef enum logic [SEL_W-1:0] {
        MV_SOLO    = 2'd0,
        MV_FOX     = 2'd1,
        MV_GOOSE   = 2'd2,
        MV_CABBAGE = 2'd3
    } move_e;

    typedef struct packed {
        bank_t bank;
        logic  reject;
        logic  solved;
    } ferry_reg_t;
endpackage

// File: rtl/ferry_move_apply.sv
module ferry_move_apply
    import ferry_pkg::*;
(
    input  bank_t            bank_i,
    input  logic [SEL_W-1:0] sel_i,
    output bank_t            cand_o,
    output logic             cargo_here_o
);
    bank_t sel_mask;
    bank_t here_match;
    bank_t flip_mask;

    for (genvar i = 0; i < PARTY_N; i++) begin : g_party
        assign sel_mask[i]   = (sel_i == SEL_W'(i));
        assign here_match[i] = sel_mask[i] && (bank_i[i] == bank_i[FARMER_IDX]);
        if (i == FARMER_IDX) begin : g_farmer
            assign flip_mask[i] = 1'b1;
        end else begin : g_cargo
            assign flip_mask[i] = sel_mask[i];
        end
    end

    assign cargo_here_o = |here_match;
    assign cand_o       = bank_i ^ flip_mask;
endmodule

// File: rtl/ferry_safety_eval.sv
module ferry_safety_eval
    import ferry_pkg::*;
(
    input  bank_t bank_i,
    output logic  unsafe_o
);
    logic [CLASH_N-1:0] clash;

    for (genvar k = 0; k < CLASH_N; k++) begin : g_clash
        assign clash[k] = (bank_i[CLASH_EATER[k]] == bank_i[CLASH_EATEN[k]])
                       && (bank_i[CLASH_EATER[k]] != bank_i[FARMER_IDX]);
    end

    assign unsafe_o = |clash;
endmodule

// File: rtl/river_ferry_fsm.sv
module river_ferry_fsm
    import ferry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               move_valid,
    input  logic [SEL_W-1:0]   move_sel,
    output logic [PARTY_N-1:0] bank,
    output logic               move_reject,
    output logic               solved
);
    ferry_reg_t st_d, st_q;
    bank_t      cand;
    logic       cargo_here;
    logic       cand_unsafe;

    ferry_move_apply u_apply (
        .bank_i       (st_q.bank),
        .sel_i        (move_sel),
        .cand_o       (cand),
        .cargo_here_o (cargo_here)
    );

    ferry_safety_eval u_safety (
        .bank_i   (cand),
        .unsafe_o (cand_unsafe)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reject = 1'b0;
        if (move_valid && cargo_here) begin
            if (cand_unsafe) begin
                st_d.reject = 1'b1;
            end else begin
                st_d.bank = cand;
            end
        end
        st_d.solved = &st_d.bank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank        = st_q.bank;
    assign move_reject = st_q.reject;
    assign solved      = st_q.solved;
endmodule

// File: rtl/river_ferry_checker.sv
module river_ferry_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       move_valid,
    input logic [1:0] move_sel,
    input logic [3:0] bank,
    input logic       move_reject,
    input logic       solved
);
    logic bank_unsafe;
    assign bank_unsafe = ((bank[1] == bank[2]) && (bank[1] != bank[0]))
                      || ((bank[2] == bank[3]) && (bank[2] != bank[0]));

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank == 4'b0000) && !move_reject && !solved);

    a_r2_farmer_always_crosses: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank) |-> (bank[0] != $past(bank[0])) && ($countones(bank ^ $past(bank)) <= 2));

    a_r4_far_cargo_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && move_sel != 2'd0 && bank[move_sel] != bank[0]) |=> $stable(bank) && !move_reject);

    a_r5_r6_never_unsafe: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_unsafe);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !move_valid |=> $stable(bank) && !move_reject);

    a_r8_solved_all_far: assert property (@(posedge clk) disable iff (!rst_n)
        solved == (bank == 4'b1111));

    a_r9_reject_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        move_reject |-> $stable(bank) && $past(move_valid));
endmodule

bind river_ferry_fsm river_ferry_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .move_valid  (move_valid),
    .move_sel    (move_sel),
    .bank        (bank),
    .move_reject (move_reject),
    .solved      (solved)
);

// File: tb/river_ferry_fsm_test.sv
module river_ferry_fsm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       move_valid = 1'b0;
    logic [1:0] move_sel = 2'd0;
    logic [3:0] bank;
    logic       move_reject;
    logic       solved;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    logic [3:0] m_bank = 4'b0000;
    logic       m_rej  = 1'b0;

    always #5 clk = ~clk;

    river_ferry_fsm uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .move_valid  (move_valid),
        .move_sel    (move_sel),
        .bank        (bank),
        .move_reject (move_reject),
        .solved      (solved)
    );

    function automatic bit fg_clash(input logic [3:0] b);
        return (b[1] == b[2]) && (b[1] != b[0]);
    endfunction

    function automatic bit gc_clash(input logic [3:0] b);
        return (b[2] == b[3]) && (b[2] != b[0]);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, check at next falling edge
    task automatic step(input logic v, input logic [1:0] s);
        logic [3:0] cand;
        logic       was_rej;
        string      tag;
        was_rej = m_rej;
        move_valid = v;
        move_sel   = s;
        m_rej = 1'b0;
        tag = "R7";
        if (v) begin
            if (s != 2'd0 && m_bank[s] != m_bank[0]) begin
                tag = "R4";
            end else begin
                cand = m_bank;
                cand[0] = ~cand[0];
                if (s != 2'd0) cand[s] = ~cand[s];
                if (fg_clash(cand)) begin
                    tag = "R5"; m_rej = 1'b1;
                end else if (gc_clash(cand)) begin
                    tag = "R6"; m_rej = 1'b1;
                end else begin
                    tag = (s == 2'd0) ? "R2" : "R3";
                    m_bank = cand;
                end
            end
        end
        @(negedge clk);
        check(tag, "bank", int'(bank), int'(m_bank));
        check((was_rej && !m_rej) ? "R9" : tag, "move_reject", int'(move_reject), int'(m_rej));
        check("R8", "solved", int'(solved), int'(m_bank == 4'b1111));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        move_valid = 1'b0;
        m_bank = 4'b0000;
        m_rej  = 1'b0;
        @(negedge clk);
        check("R1", "bank in reset", int'(bank), 0);
        check("R1", "reject in reset", int'(move_reject), 0);
        check("R1", "solved in reset", int'(solved), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "bank after reset", int'(bank), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // refused and ignored moves from the start
        step(1'b1, 2'd0);   // R5 farmer alone leaves all three
        step(1'b1, 2'd1);   // R6 fox taken, goose and cabbage remain
        step(1'b1, 2'd3);   // R5 cabbage taken, fox and goose remain
        step(1'b0, 2'd2);   // R7 idle, R9 pulse ends
        // known solution, with an ignored request mixed in
        step(1'b1, 2'd2);   // goose across
        step(1'b1, 2'd1);   // R4 fox is on the other bank
        step(1'b1, 2'd0);
        step(1'b1, 2'd1);
        step(1'b1, 2'd2);
        step(1'b1, 2'd3);
        step(1'b1, 2'd0);
        step(1'b1, 2'd2);   // R8 solved
        step(1'b0, 2'd0);
        step(1'b1, 2'd0);   // R5 farmer leaving far bank alone
        step(1'b1, 2'd2);   // R3 goose back
        check("R8", "solved cleared", int'(solved), 0);

        for (int i = 0; i < 3000; i++) begin
            if (i % 700 == 699) do_reset();
            step(($urandom % 5) != 0, 2'($urandom));
        end
        summary();
    end
endmodule